// File: doc/BRIEF.md
# Completion interrupt coalescer

This block decides when a descriptor-processing engine tells the host that work has finished. Each finished descriptor produces a one-cycle completion pulse with a flag that says whether that descriptor wants a notification. The block counts only flagged completions. It issues a notification when the count reaches a programmed limit. It also issues one when an optional timeout expires while flagged completions are still waiting.

A notification is not a level-sensitive interrupt line. It is a message write request: the block presents a 48-bit target address and a 32-bit data word, both programmed, and holds the request until the message-write port acknowledges it. Issuing a message clears the waiting count and the timer. Completions that arrive while a message is outstanding are counted toward the next message. The bus write itself happens outside this block.

Top module: `cmpl_irq_coalescer`

## Requirements
- R1: After reset, `msg_req` is 0 and `msg_addr` and `msg_data` are 0.
- R2: A completion pulse (`done_vld`=1) counts only when `done_notify`=1. Pulses with `done_notify`=0 never advance the waiting count.
- R3: When the waiting count is nonzero and at least `cfg_count_limit`, `msg_req` rises on the next clock edge. It does not rise earlier.
- R4: While `msg_req` is high, `msg_addr` equals {`cfg_addr_hi`, `cfg_addr_lo`} and `msg_data` equals `cfg_msg_data`, all as sampled at issue. Both stay stable until the acknowledge.
- R5: `msg_req` stays high until a cycle with `msg_ack`=1. It is low in the cycle after that acknowledge.
- R6: Issuing a message clears the waiting count and the timer. Completions that arrive while a message is outstanding count toward the next message, which is issued no earlier than the cycle after the acknowledge.
- R7: With `cfg_timer_en`=1, the timer starts at the first flagged completion after the count was empty. It advances once per clock. `msg_req` rises `cfg_timeout`+1 cycles after the edge that captured that first completion, even if more completions arrive later.
- R8: With `cfg_timer_en`=0, waiting completions below the limit never produce a message.
- R9: With a waiting count of zero, no message is issued, even with a limit of 0 and a timeout of 0.
- R10: A count hit and a timer expiry in the same cycle produce exactly one message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| done_vld | input | 1 | One-cycle pulse per finished descriptor |
| done_notify | input | 1 | The finished descriptor asks for notification |
| cfg_count_limit | input | 15 | Flagged-completion count that triggers a message |
| cfg_timer_en | input | 1 | Enables the timeout path |
| cfg_timeout | input | 13 | Timeout in clock cycles |
| cfg_addr_lo | input | 32 | Message target address, low word |
| cfg_addr_hi | input | 16 | Message target address, high word |
| cfg_msg_data | input | 32 | Message data word |
| msg_ack | input | 1 | Message-write port accepted the request |
| msg_req | output | 1 | Message write request |
| msg_addr | output | 48 | Message target address |
| msg_data | output | 32 | Message data word |

## Verification
The hardest situation to reach is a count hit and a timer expiry landing in the same cycle. The stimulus uses a limit of 3 and a timeout of 2, then sends three back-to-back flagged completions so that both conditions meet on the third. The bench then checks that a single acknowledge leaves nothing pending. The second hard case is completions arriving while a message is outstanding. The bench delays the acknowledge on purpose, then checks that a new request appears exactly one cycle after the acknowledge.

// File: rtl/coal_pkg.sv
package coal_pkg;
  parameter int unsigned COAL_CNT_W  = 15;
  parameter int unsigned COAL_TMR_W  = 13;
  parameter int unsigned COAL_ALO_W  = 32;
  parameter int unsigned COAL_AHI_W  = 16;
  parameter int unsigned COAL_DATA_W = 32;
endpackage

// File: rtl/coal_event_counter.sv
module coal_event_counter #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, base;

  always_comb begin
    base  = clr ? '0 : cnt_q;
    cnt_d = base;
    if (inc && (base != CNT_MAX)) cnt_d = base + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/coal_timeout_timer.sv
module coal_timeout_timer #(
  parameter int unsigned TMR_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             active,
  input  logic             clr,
  input  logic [TMR_W-1:0] limit,
  output logic             expired
);
  logic [TMR_W-1:0] tmr_q, tmr_d;
  logic             at_limit;

  assign at_limit = (tmr_q == limit);

  always_comb begin
    tmr_d = tmr_q;
    if (clr || !en || !active) tmr_d = '0;
    else if (!at_limit)        tmr_d = tmr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else        tmr_q <= tmr_d;
  end

  assign expired = en && active && at_limit;
endmodule

// File: rtl/coal_msg_issuer.sv
module coal_msg_issuer #(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              ack,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic              issue,
  output logic              req,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic              req_q, req_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign issue = fire && !req_q;

  always_comb begin
    req_d = req_q;
    if (issue)             req_d = 1'b1;
    else if (req_q && ack) req_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (issue) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign req  = req_q;
  assign addr = addr_q;
  assign data = data_q;
endmodule

// File: rtl/cmpl_irq_coalescer.sv
module cmpl_irq_coalescer
  import coal_pkg::*;
#(
  parameter int unsigned CNT_W  = COAL_CNT_W,
  parameter int unsigned TMR_W  = COAL_TMR_W,
  parameter int unsigned ALO_W  = COAL_ALO_W,
  parameter int unsigned AHI_W  = COAL_AHI_W,
  parameter int unsigned DATA_W = COAL_DATA_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   done_vld,
  input  logic                   done_notify,
  input  logic [CNT_W-1:0]       cfg_count_limit,
  input  logic                   cfg_timer_en,
  input  logic [TMR_W-1:0]       cfg_timeout,
  input  logic [ALO_W-1:0]       cfg_addr_lo,
  input  logic [AHI_W-1:0]       cfg_addr_hi,
  input  logic [DATA_W-1:0]      cfg_msg_data,
  input  logic                   msg_ack,
  output logic                   msg_req,
  output logic [ALO_W+AHI_W-1:0] msg_addr,
  output logic [DATA_W-1:0]      msg_data
);
  localparam int unsigned ADDR_W = ALO_W + AHI_W;

  logic [CNT_W-1:0] pend_cnt;
  logic             counted, pending, count_hit, tmr_expired, fire, issue;

  assign counted = done_vld && done_notify;

  coal_event_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .inc(counted), .clr(issue), .cnt(pend_cnt)
  );

  assign pending   = (pend_cnt != '0);
  assign count_hit = pending && (pend_cnt >= cfg_count_limit);

  coal_timeout_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .en(cfg_timer_en), .active(pending),
    .clr(issue), .limit(cfg_timeout), .expired(tmr_expired)
  );

  assign fire = count_hit || tmr_expired;

  coal_msg_issuer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_iss (
    .clk(clk), .rst_n(rst_n), .fire(fire), .ack(msg_ack),
    .addr_in({cfg_addr_hi, cfg_addr_lo}), .data_in(cfg_msg_data),
    .issue(issue), .req(msg_req), .addr(msg_addr), .data(msg_data)
  );
endmodule

// File: rtl/cmpl_irq_coalescer_chk.sv
module cmpl_irq_coalescer_chk #(
  parameter int unsigned CNT_W  = 15,
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_vld,
  input logic              done_notify,
  input logic              msg_ack,
  input logic              msg_req,
  input logic [ADDR_W-1:0] msg_addr,
  input logic [DATA_W-1:0] msg_data,
  input logic [CNT_W-1:0]  pend_cnt,
  input logic              issue
);
  a_r5_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !msg_ack) |=> msg_req);
  a_r5_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && msg_ack) |=> !msg_req);
  a_r4_stable_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_req && !msg_ack) |=> ($stable(msg_addr) && $stable(msg_data)));
  a_r9_no_issue_idle: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (pend_cnt != '0));
  a_r6_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> (pend_cnt <= 1));
  a_r2_flag_required: assert property (@(posedge clk) disable iff (!rst_n)
    (!(done_vld && done_notify) && !issue) |=> (pend_cnt <= $past(pend_cnt)));
  a_r10_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> !issue);
endmodule

bind cmpl_irq_coalescer cmpl_irq_coalescer_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_notify(done_notify),
  .msg_ack(msg_ack), .msg_req(msg_req), .msg_addr(msg_addr),
  .msg_data(msg_data), .pend_cnt(pend_cnt), .issue(issue)
);

// File: tb/cmpl_irq_coalescer_tb.sv
module cmpl_irq_coalescer_tb;
  logic        clk, rst_n;
  logic        done_vld, done_notify, cfg_timer_en, msg_ack, msg_req;
  logic [14:0] cfg_count_limit;
  logic [12:0] cfg_timeout;
  logic [31:0] cfg_addr_lo, cfg_msg_data, msg_data;
  logic [15:0] cfg_addr_hi;
  logic [47:0] msg_addr;
  int checks = 0, errors = 0;

  cmpl_irq_coalescer u_dut (
    .clk(clk), .rst_n(rst_n), .done_vld(done_vld), .done_notify(done_notify),
    .cfg_count_limit(cfg_count_limit), .cfg_timer_en(cfg_timer_en),
    .cfg_timeout(cfg_timeout), .cfg_addr_lo(cfg_addr_lo),
    .cfg_addr_hi(cfg_addr_hi), .cfg_msg_data(cfg_msg_data),
    .msg_ack(msg_ack), .msg_req(msg_req), .msg_addr(msg_addr),
    .msg_data(msg_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit notify);
    done_vld = 1'b1; done_notify = notify;
    @(negedge clk);
    done_vld = 1'b0; done_notify = 1'b0;
  endtask

  // Counts negedges from the current one (value start) until msg_req is seen.
  task automatic wait_req(input int start, input int limit, output int lat);
    lat = start;
    while (!msg_req && lat < limit) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic do_ack();
    msg_ack = 1'b1;
    @(negedge clk);
    msg_ack = 1'b0;
  endtask

  task automatic idle_check(input int n, input string tag);
    bit seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (msg_req) seen = 1'b1;
    end
    chk(!seen, tag, seen, 0);
  endtask

  task automatic t_reset();
    chk(msg_req == 1'b0, "R1 req", msg_req, 0);
    chk(msg_addr == '0 && msg_data == '0, "R1 payload", msg_addr, 0);
  endtask

  task automatic t_threshold();
    int lat;
    cfg_count_limit = 15'd4; cfg_timer_en = 1'b0;
    for (int i = 0; i < 3; i++) pulse(1'b1);
    chk(!msg_req, "R3 early", msg_req, 0);
    pulse(1'b1);
    wait_req(1, 40, lat);
    chk(lat == 2, "R3 latency", lat, 2);
    chk(msg_addr == {cfg_addr_hi, cfg_addr_lo}, "R4 addr", msg_addr, {cfg_addr_hi, cfg_addr_lo});
    chk(msg_data == cfg_msg_data, "R4 data", msg_data, cfg_msg_data);
    cfg_addr_lo = 32'h0; cfg_msg_data = 32'h0;
    repeat (8) @(negedge clk);
    chk(msg_req == 1'b1, "R5 hold", msg_req, 1);
    chk(msg_data == 32'hC0FF_EE11, "R4 stable", msg_data, 32'hC0FF_EE11);
  endtask

  task automatic t_outstanding();
    for (int i = 0; i < 4; i++) pulse(1'b1);
    do_ack();
    chk(!msg_req, "R5 drop", msg_req, 0);
    @(negedge clk);
    chk(msg_req, "R6 next after ack", msg_req, 1);
    do_ack();
    for (int i = 0; i < 3; i++) pulse(1'b1);
    idle_check(10, "R6 count cleared");
    pulse(1'b1);
    @(negedge clk);
    chk(msg_req, "R6 refill", msg_req, 1);
    do_ack();
  endtask

  task automatic t_flag();
    int lat;
    for (int i = 0; i < 3; i++) pulse(1'b1);
    for (int i = 0; i < 6; i++) pulse(1'b0);
    idle_check(10, "R2 unflagged ignored");
    pulse(1'b1);
    wait_req(1, 40, lat);
    chk(lat == 2, "R2 flagged counts", lat, 2);
    do_ack();
  endtask

  task automatic t_timer();
    int lat;
    cfg_count_limit = 15'd100; cfg_timer_en = 1'b1; cfg_timeout = 13'd5;
    pulse(1'b1);
    wait_req(1, 60, lat);
    chk(lat == 7, "R7 timeout", lat, 7);
    do_ack();
    cfg_timeout = 13'd6;
    pulse(1'b1);
    @(negedge clk);
    pulse(1'b1);
    wait_req(3, 60, lat);
    chk(lat == 8, "R7 from first", lat, 8);
    do_ack();
  endtask

  task automatic t_timer_off();
    cfg_timer_en = 1'b0; cfg_timeout = 13'd2;
    pulse(1'b1);
    idle_check(50, "R8 timer off");
    cfg_count_limit = 15'd1;
    @(negedge clk);
    chk(msg_req, "R8 flush", msg_req, 1);
    do_ack();
  endtask

  task automatic t_zero();
    int lat;
    cfg_count_limit = 15'd0; cfg_timer_en = 1'b1; cfg_timeout = 13'd0;
    idle_check(20, "R9 empty");
    pulse(1'b0);
    idle_check(10, "R9 unflagged");
    pulse(1'b1);
    wait_req(1, 40, lat);
    chk(lat == 2, "R9 one pending", lat, 2);
    do_ack();
  endtask

  task automatic t_both();
    int lat;
    cfg_count_limit = 15'd3; cfg_timer_en = 1'b1; cfg_timeout = 13'd2;
    for (int i = 0; i < 3; i++) pulse(1'b1);
    wait_req(1, 40, lat);
    chk(lat == 2, "R10 issue", lat, 2);
    do_ack();
    idle_check(15, "R10 single message");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; done_vld = 1'b0; done_notify = 1'b0; msg_ack = 1'b0;
    cfg_count_limit = 15'd4; cfg_timer_en = 1'b0; cfg_timeout = 13'd0;
    cfg_addr_lo = 32'h1234_5678; cfg_addr_hi = 16'hABCD; cfg_msg_data = 32'hC0FF_EE11;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_threshold();
    cfg_addr_lo = 32'h1234_5678; cfg_msg_data = 32'hC0FF_EE11;
    t_outstanding();
    t_flag();
    t_timer();
    t_timer_off();
    t_zero();
    t_both();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule